// File: doc/BRIEF.md
# Variable-Page Fully Associative Translation Buffer

This block turns virtual addresses into physical addresses using a fully associative array of translation entries. Each entry carries its own page size, so small and large pages share the array. An entry matches a request only when the partition identifier, the real-translation flag and, for non-real entries, the context identifier all agree, and the address falls inside the entry's page. The result gives a hit flag, the entry's permission bits and a physical address made from the entry's page frame and the request's in-page offset.

An insert port fills the lowest free slot. When no slot is free, it overwrites a victim slot that the caller names. Two recently used translations are kept in a small shortcut in front of the array. A shortcut slot answers only when the access-space tag, the mapping identity, the byte range and, for a write, the write permission all agree. Every insert empties the shortcut. A consistency output is raised if the valid-entry count and the free-slot count stop adding up to the array depth.

Top module: `vtlb`

## Requirements
- R1: After synchronous reset, the array holds no valid entries, `rsp_valid` and `rsp_hit` are 0, and every lookup misses.
- R2: On insert, the stored virtual base has every bit below the entry's page size cleared. Any address inside that aligned page then hits, whatever low bits the insert carried.
- R3: A lookup hits an entry only when the partition and real flag are equal. The context must also be equal, except that for a real entry the context is ignored.
- R4: The page-size code `ins_size` selects 0 = 8 KB, 1 = 64 KB, 2 = 4 MB and 3 = 256 MB. The first address past the page misses.
- R5: On a hit, `rsp_pa` equals the entry's physical address with the bits below the page size cleared, OR'd with the request address bits below the page size.
- R6: A lookup presented with `req_valid` in one cycle gives its response, with `rsp_valid` high, in the next cycle. `rsp_perm` returns the entry's 4 permission bits: bit 3 privileged, bit 2 writable, bit 1 no-fault, bit 0 side-effect.
- R7: An insert goes to the lowest-numbered free slot. When all slots are valid, it overwrites slot `ins_victim`, and the old mapping of that slot no longer hits.
- R8: `count_err` stays 0. It rises only if the number of valid entries plus the free-slot count differs from the array depth.
- R9: A repeat lookup of a page that hit in the array, with the same access-space tag and mapping identity, is answered from the shortcut (`rsp_fast` = 1) with the same result.
- R10: For a write, a shortcut slot whose entry is not writable does not answer. The response then comes from the array, with `rsp_fast` = 0, `rsp_hit` = 1 and the writable bit 0.
- R11: Any insert empties the shortcut, so the next lookup has `rsp_fast` = 0.
- R12: A shortcut slot whose access-space tag differs from `req_asi` does not answer.
- R13: When several valid entries match, the lowest-numbered slot supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert strobe |
| ins_va | input | 48 | Insert virtual address (low bits are cleared on store) |
| ins_size | input | 2 | Insert page-size code |
| ins_part | input | 8 | Insert partition identifier |
| ins_ctx | input | 13 | Insert context identifier |
| ins_real | input | 1 | Insert real-translation flag |
| ins_pa | input | 40 | Insert physical address |
| ins_perm | input | 4 | Insert permission bits |
| ins_victim | input | 6 | Slot overwritten when the array is full |
| req_valid | input | 1 | Lookup strobe |
| req_va | input | 48 | Lookup virtual address |
| req_len | input | 2 | Log2 of access size in bytes |
| req_write | input | 1 | Lookup is a write |
| req_asi | input | 8 | Access-space tag |
| req_part | input | 8 | Lookup partition identifier |
| req_ctx | input | 13 | Lookup context identifier |
| req_real | input | 1 | Lookup real-translation flag |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found |
| rsp_fast | output | 1 | Response came from the shortcut |
| rsp_pa | output | 40 | Formed physical address |
| rsp_perm | output | 4 | Permission bits of the hit entry |
| count_err | output | 1 | Valid/free count mismatch |

## Verification
The hardest state to reach is a write to a read-only page whose translation already sits in the shortcut. That is the only case where the shortcut holds a matching slot but must decline and pass the lookup to the array. The stimulus gets there with a read of the read-only page, which fills a shortcut slot, followed at once by a write to the same address. Slot replacement when the array is full is reached by first sweeping all 64 slots with pages of every size, then naming victims explicitly. Priority among overlapping entries is reached by placing a duplicate page at a higher slot than its twin.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

    localparam int unsigned VA_W   = 48;
    localparam int unsigned PA_W   = 40;
    localparam int unsigned PART_W = 8;
    localparam int unsigned CTX_W  = 13;
    localparam int unsigned ASI_W  = 8;

    typedef enum logic [1:0] {
        PG_8K   = 2'd0,
        PG_64K  = 2'd1,
        PG_4M   = 2'd2,
        PG_256M = 2'd3
    } pg_size_e;

    typedef struct packed {
        logic priv;
        logic writable;
        logic nofault;
        logic side_effect;
    } perm_t;

    typedef struct packed {
        logic [VA_W-1:0]   base;
        pg_size_e          size;
        logic [PART_W-1:0] part;
        logic [CTX_W-1:0]  ctx;
        logic              is_real;
        logic [PA_W-1:0]   pa;
        perm_t             perm;
    } tlb_entry_t;

    function automatic int unsigned page_shift(pg_size_e s);
        case (s)
            PG_8K:   return 13;
            PG_64K:  return 16;
            PG_4M:   return 22;
            default: return 28;
        endcase
    endfunction

    function automatic logic [VA_W-1:0] va_off_mask(pg_size_e s);
        return (VA_W'(1) << page_shift(s)) - VA_W'(1);
    endfunction

    function automatic logic [PA_W-1:0] pa_off_mask(pg_size_e s);
        return (PA_W'(1) << page_shift(s)) - PA_W'(1);
    endfunction

    function automatic logic [PA_W-1:0] form_pa(tlb_entry_t e, logic [VA_W-1:0] va);
        logic [PA_W-1:0] m;
        m = pa_off_mask(e.size);
        return (e.pa & ~m) | (va[PA_W-1:0] & m);
    endfunction

    function automatic logic ident_match(tlb_entry_t e, logic [PART_W-1:0] part,
                                         logic [CTX_W-1:0] ctx, logic is_real);
        return (e.part == part) && (e.is_real == is_real) && (is_real || (e.ctx == ctx));
    endfunction

endpackage

// File: rtl/vtlb_entry_store.sv
module vtlb_entry_store
    import vtlb_pkg::*;
#(
    parameter  int unsigned ENTRIES = 64,
    localparam int unsigned IDX_W   = $clog2(ENTRIES),
    localparam int unsigned CNT_W   = $clog2(ENTRIES + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ins_valid,
    input  tlb_entry_t                ins_entry,
    input  logic [IDX_W-1:0]          ins_victim,
    output tlb_entry_t [ENTRIES-1:0]  entries,
    output logic [ENTRIES-1:0]        valid,
    output logic [CNT_W-1:0]          free_cnt
);

    logic             any_free;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] target;
    tlb_entry_t       aligned;

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign target = any_free ? free_idx : ins_victim;

    always_comb begin
        aligned      = ins_entry;
        aligned.base = ins_entry.base & ~va_off_mask(ins_entry.size);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid    <= '0;
            free_cnt <= CNT_W'(ENTRIES);
        end else if (ins_valid) begin
            valid[target] <= 1'b1;
            if (!valid[target]) begin
                free_cnt <= free_cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (ins_valid) begin
            entries[target] <= aligned;
        end
    end

endmodule

// File: rtl/vtlb_match.sv
module vtlb_match
    import vtlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 64
) (
    input  tlb_entry_t [ENTRIES-1:0] entries,
    input  logic [ENTRIES-1:0]       valid,
    input  logic [VA_W-1:0]          req_va,
    input  logic [PART_W-1:0]        req_part,
    input  logic [CTX_W-1:0]         req_ctx,
    input  logic                     req_real,
    output logic                     hit,
    output tlb_entry_t               hit_entry
);

    logic [ENTRIES-1:0] hits;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hits[g] = valid[g]
                      && ident_match(entries[g], req_part, req_ctx, req_real)
                      && ((req_va & ~va_off_mask(entries[g].size)) == entries[g].base);
    end

    assign hit = |hits;

    always_comb begin
        hit_entry = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) begin
                hit_entry = entries[i];
            end
        end
    end

endmodule

// File: rtl/vtlb_shortcut.sv
module vtlb_shortcut
    import vtlb_pkg::*;
#(
    parameter  int unsigned SLOTS = 2,
    localparam int unsigned SEL_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               fill,
    input  tlb_entry_t         fill_entry,
    input  logic [ASI_W-1:0]   req_asi,
    input  logic [VA_W-1:0]    req_va,
    input  logic [1:0]         req_len,
    input  logic               req_write,
    input  logic [PART_W-1:0]  req_part,
    input  logic [CTX_W-1:0]   req_ctx,
    input  logic               req_real,
    output logic               fast_hit,
    output tlb_entry_t         fast_entry,
    output logic [SLOTS-1:0]   slot_valid
);

    tlb_entry_t [SLOTS-1:0] slot_e;
    logic [SLOTS-1:0][ASI_W-1:0] slot_asi;
    logic [SLOTS-1:0]       slot_hit;
    logic [SEL_W-1:0]       next_slot;
    logic [VA_W:0]          req_end;

    assign req_end = {1'b0, req_va} + ((VA_W + 1)'(1) << req_len);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [VA_W:0] pg_lo;
        logic [VA_W:0] pg_hi;
        assign pg_lo = {1'b0, slot_e[g].base};
        assign pg_hi = pg_lo + ((VA_W + 1)'(1) << page_shift(slot_e[g].size));
        assign slot_hit[g] = slot_valid[g]
                          && (slot_asi[g] == req_asi)
                          && ident_match(slot_e[g], req_part, req_ctx, req_real)
                          && (pg_lo < req_end)
                          && (pg_hi > {1'b0, req_va})
                          && (!req_write || slot_e[g].perm.writable);
    end

    assign fast_hit = |slot_hit;

    always_comb begin
        fast_entry = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (slot_hit[i]) begin
                fast_entry = slot_e[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            slot_valid <= '0;
            next_slot  <= '0;
        end else if (fill) begin
            slot_valid[next_slot] <= 1'b1;
            slot_e[next_slot]     <= fill_entry;
            slot_asi[next_slot]   <= req_asi;
            next_slot <= (next_slot == SEL_W'(SLOTS - 1)) ? '0 : next_slot + SEL_W'(1);
        end
    end

endmodule

// File: rtl/vtlb.sv
module vtlb
    import vtlb_pkg::*;
#(
    parameter  int unsigned ENTRIES  = 64,
    parameter  int unsigned SC_SLOTS = 2,
    localparam int unsigned IDX_W    = $clog2(ENTRIES),
    localparam int unsigned CNT_W    = $clog2(ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    input  logic [VA_W-1:0]   ins_va,
    input  logic [1:0]        ins_size,
    input  logic [PART_W-1:0] ins_part,
    input  logic [CTX_W-1:0]  ins_ctx,
    input  logic              ins_real,
    input  logic [PA_W-1:0]   ins_pa,
    input  logic [3:0]        ins_perm,
    input  logic [IDX_W-1:0]  ins_victim,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_va,
    input  logic [1:0]        req_len,
    input  logic              req_write,
    input  logic [ASI_W-1:0]  req_asi,
    input  logic [PART_W-1:0] req_part,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic              req_real,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_fast,
    output logic [PA_W-1:0]   rsp_pa,
    output logic [3:0]        rsp_perm,
    output logic              count_err
);

    tlb_entry_t               ins_entry;
    tlb_entry_t [ENTRIES-1:0] entries;
    logic [ENTRIES-1:0]       valid;
    logic [CNT_W-1:0]         free_cnt;
    logic                     arr_hit;
    tlb_entry_t               arr_entry;
    logic                     fast_hit;
    tlb_entry_t               fast_entry;
    logic [SC_SLOTS-1:0]      sc_valid;
    logic                     sc_fill;
    tlb_entry_t               sel_entry;

    always_comb begin
        ins_entry.base    = ins_va;
        ins_entry.size    = pg_size_e'(ins_size);
        ins_entry.part    = ins_part;
        ins_entry.ctx     = ins_ctx;
        ins_entry.is_real = ins_real;
        ins_entry.pa      = ins_pa;
        ins_entry.perm    = perm_t'(ins_perm);
    end

    vtlb_entry_store #(.ENTRIES(ENTRIES)) store_i (
        .clk        (clk),
        .rst        (rst),
        .ins_valid  (ins_valid),
        .ins_entry  (ins_entry),
        .ins_victim (ins_victim),
        .entries    (entries),
        .valid      (valid),
        .free_cnt   (free_cnt)
    );

    vtlb_match #(.ENTRIES(ENTRIES)) match_i (
        .entries   (entries),
        .valid     (valid),
        .req_va    (req_va),
        .req_part  (req_part),
        .req_ctx   (req_ctx),
        .req_real  (req_real),
        .hit       (arr_hit),
        .hit_entry (arr_entry)
    );

    assign sc_fill = req_valid && arr_hit && !fast_hit && !ins_valid;

    vtlb_shortcut #(.SLOTS(SC_SLOTS)) shortcut_i (
        .clk        (clk),
        .rst        (rst),
        .flush      (ins_valid),
        .fill       (sc_fill),
        .fill_entry (arr_entry),
        .req_asi    (req_asi),
        .req_va     (req_va),
        .req_len    (req_len),
        .req_write  (req_write),
        .req_part   (req_part),
        .req_ctx    (req_ctx),
        .req_real   (req_real),
        .fast_hit   (fast_hit),
        .fast_entry (fast_entry),
        .slot_valid (sc_valid)
    );

    assign sel_entry = fast_hit ? fast_entry : arr_entry;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fast  <= 1'b0;
            rsp_pa    <= '0;
            rsp_perm  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && (fast_hit || arr_hit);
            rsp_fast  <= req_valid && fast_hit;
            rsp_pa    <= form_pa(sel_entry, req_va);
            rsp_perm  <= sel_entry.perm;
        end
    end

    assign count_err = (int'($countones(valid)) + int'(free_cnt)) != int'(ENTRIES);

endmodule

// File: rtl/vtlb_checker.sv
module vtlb_checker #(
    parameter int unsigned SC_SLOTS = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                ins_valid,
    input logic                req_valid,
    input logic                req_write,
    input logic [47:0]         req_va,
    input logic                rsp_valid,
    input logic                rsp_hit,
    input logic                rsp_fast,
    input logic [39:0]         rsp_pa,
    input logic [3:0]          rsp_perm,
    input logic                count_err,
    input logic [SC_SLOTS-1:0] sc_valid
);

    p_counts_agree_r8: assert property (@(posedge clk) disable iff (rst)
        !count_err);

    p_resp_next_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    p_fast_is_hit_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_fast |-> rsp_hit);

    p_fast_write_ok_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_write |=> (!rsp_fast || rsp_perm[2]));

    p_insert_flushes_r11: assert property (@(posedge clk) disable iff (rst)
        ins_valid |=> (sc_valid == '0));

    p_offset_kept_r5: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (!rsp_hit || (rsp_pa[12:0] == $past(req_va[12:0]))));

endmodule

bind vtlb vtlb_checker #(.SC_SLOTS(SC_SLOTS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .ins_valid (ins_valid),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_va    (req_va),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_fast  (rsp_fast),
    .rsp_pa    (rsp_pa),
    .rsp_perm  (rsp_perm),
    .count_err (count_err),
    .sc_valid  (sc_valid)
);

// File: tb/vtlb_tb_top.sv
module vtlb_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ins_valid = 1'b0;
    logic [47:0] ins_va = '0;
    logic [1:0]  ins_size = '0;
    logic [7:0]  ins_part = '0;
    logic [12:0] ins_ctx = '0;
    logic        ins_real = 1'b0;
    logic [39:0] ins_pa = '0;
    logic [3:0]  ins_perm = '0;
    logic [5:0]  ins_victim = '0;
    logic        req_valid = 1'b0;
    logic [47:0] req_va = '0;
    logic [1:0]  req_len = '0;
    logic        req_write = 1'b0;
    logic [7:0]  req_asi = '0;
    logic [7:0]  req_part = '0;
    logic [12:0] req_ctx = '0;
    logic        req_real = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_fast, count_err;
    logic [39:0] rsp_pa;
    logic [3:0]  rsp_perm;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vtlb dut_i (
        .clk(clk), .rst(rst),
        .ins_valid(ins_valid), .ins_va(ins_va), .ins_size(ins_size), .ins_part(ins_part),
        .ins_ctx(ins_ctx), .ins_real(ins_real), .ins_pa(ins_pa), .ins_perm(ins_perm),
        .ins_victim(ins_victim),
        .req_valid(req_valid), .req_va(req_va), .req_len(req_len), .req_write(req_write),
        .req_asi(req_asi), .req_part(req_part), .req_ctx(req_ctx), .req_real(req_real),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fast(rsp_fast), .rsp_pa(rsp_pa),
        .rsp_perm(rsp_perm), .count_err(count_err)
    );

    function automatic int shift_of(int sz);
        case (sz)
            0:       return 13;
            1:       return 16;
            2:       return 22;
            default: return 28;
        endcase
    endfunction

    function automatic logic [63:0] mask_of(int sz);
        return (64'd1 << shift_of(sz)) - 64'd1;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic insert(input logic [47:0] va, input int sz, input logic [7:0] part,
                          input logic [12:0] ctx, input bit rl, input logic [39:0] pa,
                          input logic [3:0] perm, input logic [5:0] victim);
        ins_valid = 1'b1; ins_va = va; ins_size = 2'(sz); ins_part = part;
        ins_ctx = ctx; ins_real = rl; ins_pa = pa; ins_perm = perm; ins_victim = victim;
        @(posedge clk);
        @(negedge clk);
        ins_valid = 1'b0;
        check(count_err == 1'b0, "R8", 64'(count_err), 64'd0);
    endtask

    task automatic lookup(input logic [47:0] va, input logic [7:0] part, input logic [12:0] ctx,
                          input bit rl, input logic [7:0] asi, input bit wr);
        req_valid = 1'b1; req_va = va; req_part = part; req_ctx = ctx;
        req_real = rl; req_asi = asi; req_write = wr; req_len = 2'd2;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [47:0] base, lva;
        logic [39:0] pa_i;
        logic [63:0] pm, exp_pa;

        do_reset();
        // R1: reset state
        check(rsp_valid == 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'd0);
        check(rsp_hit == 1'b0, "R1 rsp_hit", 64'(rsp_hit), 64'd0);
        check(count_err == 1'b0, "R1 count_err", 64'(count_err), 64'd0);
        lookup(48'h0, 8'd0, 13'd0, 1'b0, 8'd0, 1'b0);
        check(rsp_valid == 1'b1, "R6 valid after lookup", 64'(rsp_valid), 64'd1);
        check(rsp_hit == 1'b0, "R1 empty miss", 64'(rsp_hit), 64'd0);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R6 idle", 64'(rsp_valid), 64'd0);

        // Fill every slot, sizes cycling through all four codes (R2, R4, R7)
        for (int i = 0; i < N; i++) begin
            insert(48'((64'(i) << 30) | 64'h0ABC_DEF), i % 4, 8'(i % 3), 13'(i * 7),
                   (i % 8) == 7, 40'((64'(i) << 30) | 64'h1555_5555), 4'(i % 16), 6'd0);
        end

        // Sweep every entry
        for (int i = 0; i < N; i++) begin
            pm     = mask_of(i % 4);
            base   = 48'(((64'(i) << 30) | 64'h0ABC_DEF) & ~pm);
            pa_i   = 40'((64'(i) << 30) | 64'h1555_5555);
            lva    = 48'(64'(base) | (64'h0765_4321 & pm));
            exp_pa = ((64'(pa_i) & ~pm) | (64'(lva) & pm)) & 64'hFF_FFFF_FFFF;
            lookup(lva, 8'(i % 3), 13'(i * 7), (i % 8) == 7, 8'd0, 1'b0);
            check(rsp_hit == 1'b1, "R2 in-page hit", 64'(rsp_hit), 64'd1);
            check(64'(rsp_pa) == exp_pa, "R5 pa", 64'(rsp_pa), exp_pa);
            check(rsp_perm == 4'(i % 16), "R6 perm", 64'(rsp_perm), 64'(i % 16));
            lookup(48'(64'(base) + pm + 64'd1), 8'(i % 3), 13'(i * 7), (i % 8) == 7, 8'd0, 1'b0);
            check(rsp_hit == 1'b0, "R4 past page end", 64'(rsp_hit), 64'd0);
            lookup(lva, 8'((i % 3) + 1), 13'(i * 7), (i % 8) == 7, 8'd0, 1'b0);
            check(rsp_hit == 1'b0, "R3 partition", 64'(rsp_hit), 64'd0);
            lookup(lva, 8'(i % 3), 13'(i * 7 + 1), (i % 8) == 7, 8'd0, 1'b0);
            check(rsp_hit == ((i % 8) == 7), "R3 context", 64'(rsp_hit), 64'((i % 8) == 7));
            lookup(lva, 8'(i % 3), 13'(i * 7), (i % 8) != 7, 8'd0, 1'b0);
            check(rsp_hit == 1'b0, "R3 real flag", 64'(rsp_hit), 64'd0);
        end

        // R7: full array, victim overwrite of slot 5
        insert(48'h19_0000_0000, 0, 8'd1, 13'd9, 1'b0, 40'h12_3450_0000, 4'h4, 6'd5);
        lookup(48'(((64'd5 << 30) | 64'h0ABC_DEF) & ~mask_of(1)), 8'd2, 13'd35, 1'b0, 8'd0, 1'b0);
        check(rsp_hit == 1'b0, "R7 old mapping gone", 64'(rsp_hit), 64'd0);
        lookup(48'h19_0000_0123, 8'd1, 13'd9, 1'b0, 8'd0, 1'b0);
        check(rsp_hit == 1'b1, "R7 new mapping", 64'(rsp_hit), 64'd1);
        check(rsp_pa == 40'h12_3450_0123, "R7 new pa", 64'(rsp_pa), 64'h12_3450_0123);

        // R13: duplicate page at slot 3 and then slot 10; lower slot wins
        insert(48'h20_0000_0000, 1, 8'd4, 13'd4, 1'b0, 40'h00_AAAA_0000, 4'h1, 6'd3);
        insert(48'h20_0000_0000, 1, 8'd4, 13'd4, 1'b0, 40'h00_BBBB_0000, 4'h2, 6'd10);
        lookup(48'h20_0000_0042, 8'd4, 13'd4, 1'b0, 8'd0, 1'b0);
        check(rsp_pa == 40'h00_AAAA_0042, "R13 low slot pa", 64'(rsp_pa), 64'h00_AAAA_0042);
        check(rsp_perm == 4'h1, "R13 low slot perm", 64'(rsp_perm), 64'h1);

        // Shortcut behaviour
        do_reset();
        insert(48'h1_0000_2000, 0, 8'd0, 13'd5, 1'b0, 40'h0_5000_0000, 4'b0100, 6'd0);
        insert(48'h1_0001_0000, 1, 8'd0, 13'd5, 1'b0, 40'h0_6000_0000, 4'b0000, 6'd0);
        lookup(48'h1_0000_2010, 8'd0, 13'd5, 1'b0, 8'h80, 1'b0);
        check(rsp_hit == 1'b1 && rsp_fast == 1'b0, "R9 first lookup from array",
              64'({rsp_hit, rsp_fast}), 64'b10);
        lookup(48'h1_0000_2020, 8'd0, 13'd5, 1'b0, 8'h80, 1'b0);
        check(rsp_fast == 1'b1, "R9 repeat is fast", 64'(rsp_fast), 64'd1);
        check(rsp_pa == 40'h0_5000_0020, "R9 fast pa", 64'(rsp_pa), 64'h0_5000_0020);
        lookup(48'h1_0000_2020, 8'd0, 13'd5, 1'b0, 8'h81, 1'b0);
        check(rsp_fast == 1'b0 && rsp_hit == 1'b1, "R12 asi mismatch", 64'({rsp_hit, rsp_fast}), 64'b10);
        lookup(48'h1_0000_2030, 8'd0, 13'd5, 1'b0, 8'h80, 1'b1);
        check(rsp_fast == 1'b1, "R10 writable fast write", 64'(rsp_fast), 64'd1);
        lookup(48'h1_0001_0040, 8'd0, 13'd5, 1'b0, 8'h80, 1'b0);
        lookup(48'h1_0001_0040, 8'd0, 13'd5, 1'b0, 8'h80, 1'b0);
        check(rsp_fast == 1'b1, "R9 read-only page fast read", 64'(rsp_fast), 64'd1);
        lookup(48'h1_0001_0040, 8'd0, 13'd5, 1'b0, 8'h80, 1'b1);
        check(rsp_fast == 1'b0 && rsp_hit == 1'b1, "R10 write declined by shortcut",
              64'({rsp_hit, rsp_fast}), 64'b10);
        check(rsp_perm[2] == 1'b0, "R10 writable bit", 64'(rsp_perm), 64'h0);
        lookup(48'h1_0001_0040, 8'd0, 13'd5, 1'b0, 8'h80, 1'b0);
        check(rsp_fast == 1'b1, "R9 read after declined write", 64'(rsp_fast), 64'd1);
        insert(48'h3_0000_0000, 0, 8'd0, 13'd5, 1'b0, 40'h0, 4'h0, 6'd0);
        lookup(48'h1_0001_0040, 8'd0, 13'd5, 1'b0, 8'h80, 1'b0);
        check(rsp_fast == 1'b0 && rsp_hit == 1'b1, "R11 insert flushes", 64'({rsp_hit, rsp_fast}), 64'b10);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule